// File: doc/BRIEF.md
# Windowed Link Address Translator

This block rebases addresses for a memory-mapped point-to-point serial link, in both directions. An outbound request carries a local bus address. The block keeps only its low 26 bits and subtracts a single programmable transmit base to form the address used at the far end.

An inbound request carries an address taken from a received packet. The block places that address into one of four receive windows. The windows sit back to back: window 1 starts at zero, and each later window starts where the previous one ends. The block then relocates the address by the matched window's offset. An inbound address beyond the last window is reported as a miss.

Each request is presented with a valid strobe and a direction bit. The result appears one clock later with its own valid strobe and a miss flag. The nine configuration registers (the transmit base, plus a size and an offset per window) are loaded through a simple write port.

Top module: `link_xlate`

## Requirements
- R1: After reset `rsp_valid`, `rsp_addr` and `rsp_miss` are 0, and every configuration register is 0. As a result, an outbound address comes out as its low 26 bits, and every inbound address misses.
- R2: When `cfg_we` is 1 on a clock edge, the register picked by `cfg_sel` is written. Select 0 is the transmit base, 2k+1 is the size of window k+1, and 2k+2 is the offset of window k+1 (k = 0..3). Bits [1:0] of the written value are stored as 0.
- R3: An outbound request (`req_inbound` = 0) yields `rsp_addr` = (`req_addr`[25:0] zero-extended − transmit base) mod 2^32, with `rsp_miss` = 0. With a base of 0, address 0x0C00_0054 yields 0x0000_0054.
- R4: An inbound address A below size1 yields A + offset1 (mod 2^32) with `rsp_miss` = 0.
- R5: For window n (n = 2..4), let S be the sum of sizes 1..n−1, computed without overflow. An inbound address A with S ≤ A < S + size n yields (A − S) + offset n (mod 2^32) with `rsp_miss` = 0. A window of size 0 matches nothing.
- R6: An inbound address at or beyond the sum of all four sizes gives `rsp_miss` = 1 and `rsp_addr` = 0.
- R7: `rsp_valid` equals `req_valid` of the previous cycle. While `req_valid` is 0, `rsp_addr` and `rsp_miss` hold their values.
- R8: A request in the same cycle as a register write is translated with the register values from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Register select (see R2) |
| cfg_wdata | input | 32 | Register write value |
| req_valid | input | 1 | Request strobe |
| req_inbound | input | 1 | 1 = received address, 0 = outbound address |
| req_addr | input | 32 | Address to translate |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_addr | output | 32 | Translated address |
| rsp_miss | output | 1 | Inbound address outside all windows |

## Verification
Inbound translation is swept word by word across a layout that has unequal windows, one of them empty. The sweep continues past the last window, so every boundary between two windows, and the boundary into the miss region, is hit on both sides. A second layout has sizes large enough that their sum exceeds 32 bits, which separates a wide comparison from a wrapped one. Outbound translation is tried with several bases, including one with set low bits and one larger than the 26-bit field, so that truncation, wrap and base alignment are all distinguished. Unaligned write data, idle cycles, and a write in the same cycle as a request tell apart masking, holding and register timing.

// File: rtl/link_xlate.sv
module link_xlate #(
  parameter int AW         = 32,
  parameter int LOCAL_BITS = 26,
  parameter int NWIN       = 4,
  parameter int SELW       = $clog2(2*NWIN+1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [SELW-1:0] cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          req_valid,
  input  logic          req_inbound,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_addr,
  output logic          rsp_miss
);
  localparam logic [AW-1:0] ALIGN_MASK = ~AW'(3);
  localparam logic [AW-1:0] LOCAL_MASK = {{(AW-LOCAL_BITS){1'b0}}, {LOCAL_BITS{1'b1}}};

  logic [AW-1:0] tx_base;
  logic [AW-1:0] win_size [NWIN];
  logic [AW-1:0] win_off  [NWIN];
  logic [AW:0]   win_lo   [NWIN+1];
  logic [AW-1:0] in_addr, out_addr;
  logic          in_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_base <= '0;
      for (int k = 0; k < NWIN; k++) begin
        win_size[k] <= '0;
        win_off[k]  <= '0;
      end
    end else if (cfg_we) begin
      if (cfg_sel == '0) tx_base <= cfg_wdata & ALIGN_MASK;
      for (int k = 0; k < NWIN; k++) begin
        if (cfg_sel == SELW'(2*k+1)) win_size[k] <= cfg_wdata & ALIGN_MASK;
        if (cfg_sel == SELW'(2*k+2)) win_off[k]  <= cfg_wdata & ALIGN_MASK;
      end
    end
  end

  always_comb begin
    win_lo[0] = '0;
    for (int k = 0; k < NWIN; k++)
      win_lo[k+1] = win_lo[k] + {1'b0, win_size[k]};
    in_hit  = 1'b0;
    in_addr = '0;
    for (int k = NWIN-1; k >= 0; k--) begin
      if ({1'b0, req_addr} >= win_lo[k] && {1'b0, req_addr} < win_lo[k+1]) begin
        in_hit  = 1'b1;
        in_addr = req_addr - win_lo[k][AW-1:0] + win_off[k];
      end
    end
  end

  assign out_addr = (req_addr & LOCAL_MASK) - tx_base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_miss  <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_addr <= req_inbound ? in_addr : out_addr;
        rsp_miss <= req_inbound & ~in_hit;
      end
    end
  end
endmodule

// File: rtl/link_xlate_chk.sv
module link_xlate_chk #(
  parameter int AW   = 32,
  parameter int SELW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_inbound,
  input logic [AW-1:0] req_addr,
  input logic          rsp_valid,
  input logic [AW-1:0] rsp_addr,
  input logic          rsp_miss
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> rsp_valid); // R7
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !rsp_valid); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(rsp_addr) && $stable(rsp_miss))); // R7
  AST_OUTBOUND_NO_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_inbound) |=> !rsp_miss); // R3
  AST_MISS_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_miss) |-> (rsp_addr == '0)); // R6
  AST_ALIGNED_KEEPS_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[1:0] == 2'b00) |=> (rsp_addr[1:0] == 2'b00)); // R2
endmodule

bind link_xlate link_xlate_chk #(.AW(AW), .SELW(SELW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_inbound(req_inbound),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_miss(rsp_miss));

// File: tb/link_xlate_tb.sv
module link_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_inbound = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic [31:0] rsp_addr;
  logic        rsp_miss;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m_base;
  logic [31:0] m_size [4];
  logic [31:0] m_off  [4];

  always #4 clk = ~clk;

  link_xlate u_dut (.*);

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic mirror_clear();
    m_base = '0;
    for (int k = 0; k < 4; k++) begin m_size[k] = '0; m_off[k] = '0; end
  endtask

  task automatic mirror_write(logic [3:0] sel, logic [31:0] d);
    if (sel == 0) m_base = d & ~32'h3;
    else if (sel[0]) m_size[(sel-1)/2] = d & ~32'h3;
    else m_off[(sel-2)/2] = d & ~32'h3;
  endtask

  task automatic wr(logic [3:0] sel, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    mirror_write(sel, d);
  endtask

  function automatic logic [32:0] exp_in(logic [31:0] a);
    logic [32:0] lo;
    lo = '0;
    for (int k = 0; k < 4; k++) begin
      if ({1'b0, a} >= lo && {1'b0, a} < lo + {1'b0, m_size[k]})
        return {1'b0, a - lo[31:0] + m_off[k]};
      lo = lo + {1'b0, m_size[k]};
    end
    return {1'b1, 32'h0};
  endfunction

  task automatic req(string tag, logic inb, logic [31:0] a);
    logic [32:0] e;
    @(negedge clk);
    req_valid = 1'b1; req_inbound = inb; req_addr = a;
    e = inb ? exp_in(a) : {1'b0, (a & 32'h03FF_FFFF) - m_base};
    @(posedge clk); #1;
    req_valid = 1'b0;
    check({tag, " valid"}, {31'b0, rsp_valid}, 32'd1);
    check({tag, " addr"}, rsp_addr, e[31:0]);
    check({tag, " miss"}, {31'b0, rsp_miss}, {31'b0, e[32]});
  endtask

  initial begin
    logic [31:0] held;
    mirror_clear();
    #20;
    check("R1 reset valid", {31'b0, rsp_valid}, 0);
    check("R1 reset addr", rsp_addr, 0);
    check("R1 reset miss", {31'b0, rsp_miss}, 0);
    @(negedge clk); rst_n = 1'b1;
    req("R1 outbound after reset", 1'b0, 32'hFFFF_FFF8);
    req("R1 inbound miss after reset", 1'b1, 32'h0000_0010);

    wr(1, 32'h0000_0103); wr(2, 32'h8000_0001);
    wr(3, 32'h0000_0040); wr(4, 32'h0000_1000);
    wr(5, 32'h0);         wr(6, 32'h0000_5550);
    wr(7, 32'h0000_0200); wr(8, 32'hFFFF_FF00);
    req("R2 masked size edge", 1'b1, 32'h0000_00FC);
    req("R2 masked size over", 1'b1, 32'h0000_0100);
    for (int a = 0; a < 32'h3A0; a += 4) begin
      if (a < 32'h100) req("R4 sweep", 1'b1, a);
      else if (a < 32'h340) req("R5 sweep", 1'b1, a);
      else req("R6 sweep", 1'b1, a);
    end
    for (int a = 32'h13C; a < 32'h148; a++) req("R5 unaligned boundary", 1'b1, a);
    req("R6 top address", 1'b1, 32'hFFFF_FFFF);

    begin : hold_chk
      held = rsp_addr;
      @(negedge clk); @(negedge clk);
      check("R7 idle valid", {31'b0, rsp_valid}, 0);
      check("R7 idle holds addr", rsp_addr, held);
    end

    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 4'd1; cfg_wdata = 32'h0000_0010;
    req_valid = 1'b1; req_inbound = 1'b1; req_addr = 32'h0000_0020;
    @(posedge clk); #1;
    cfg_we = 1'b0; req_valid = 1'b0;
    check("R8 same-cycle write uses old size", rsp_addr, 32'h8000_0020);
    check("R8 same-cycle miss", {31'b0, rsp_miss}, 0);
    mirror_write(4'd1, 32'h0000_0010);
    req("R8 new size takes effect", 1'b1, 32'h0000_0020);

    wr(1, 32'hF000_0000); wr(3, 32'hF000_0000); wr(5, 32'h0); wr(7, 32'h0);
    for (int a = 32'hEFFF_FFF0; a != 32'hF000_0010; a += 4) req("R5 large window boundary", 1'b1, a);
    req("R5 beyond 32-bit sum", 1'b1, 32'hFFFF_FFFC);

    foreach (m_off[k]) begin end
    req("R3 base zero example", 1'b0, 32'h0C00_0054);
    wr(0, 32'h0000_0057);
    req("R3 base aligned", 1'b0, 32'h0C00_0054);
    req("R3 base wrap", 1'b0, 32'h0000_0010);
    wr(0, 32'h1000_0000);
    for (int a = 0; a < 64; a++) req("R3 sweep", 1'b0, 32'hFC00_0000 + a * 32'h0010_0001);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule